// File: doc/BRIEF.md
# Asynchronous Serial Port with Receive Qualification

This block is a full-duplex asynchronous serial port for a 10-bit character frame. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. A one-cycle write strobe loads a byte into the transmitter. The transmitter adds the start and stop bits, shifts the frame out on the transmit pin, and raises a transmit-done flag when the stop bit has been sent. Only the clear strobe from software lowers that flag.

The receiver runs only while its enable input is high. It watches the line for a high-to-low transition and samples each bit sixteen times. Every bit value is a two-of-three vote taken in the middle of the bit. A completed frame is kept only when two conditions hold: the receive-done flag is still clear, and either the qualification input is low or the stop bit read high. A kept frame places its byte in the receive buffer, copies its stop bit into a separate flag bit and sets the receive-done flag. A frame that fails the conditions is discarded, and the receiver goes back to waiting for a start edge.

Timing comes from an external pulse that a timer issues on each overflow. These pulses are divided by PRE_DIV (32) to form the sample tick. The sample tick is divided by OVS (16) to form one bit period.

Top module: `uartq_top`

## Requirements
- R1: The transmit pin idles high. A frame is a 0 start bit, eight data bits LSB first, then a 1 stop bit. Each bit lasts OVS sample ticks, and one sample tick occurs every PRE_DIV overflow pulses.
- R2: A transmit write strobe drives the transmit pin low in the next clock cycle.
- R3: The transmit-done flag rises in the cycle after the last sample tick of the stop bit. It stays high until the clear strobe. A set in the same cycle as a clear wins.
- R4: A second write during a frame abandons the unsent remainder and restarts with the new byte. The transmit-done flag is not set for the abandoned byte.
- R5: Reception starts only with the enable high and a 1-to-0 change on the line, seen between two sample ticks. With the enable low the receiver returns to idle and frames leave every output unchanged.
- R6: Each bit is the majority of samples 7, 8 and 9 after the start edge. A start bit that votes high is rejected as a glitch, and a following valid frame is still received.
- R7: An accepted frame loads the byte into the receive buffer and the stop bit into the stop flag, and sets the receive-done flag.
- R8: A frame that completes while the receive-done flag is set is dropped. The buffer and the stop flag keep their values.
- R9: With qualification high, a frame whose stop bit is 0 is dropped. With qualification low, the same frame is accepted with the stop flag 0.
- R10: The receive-done flag clears on its clear strobe. A set in the same cycle as a clear wins.
- R11: After reset the transmit pin is 1, and both done flags, the stop flag and the receive buffer are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_ovf_i | input | 1 | One-cycle pulse on each timer overflow |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | 8 | Byte to send |
| ti_clr_i | input | 1 | Clears the transmit-done flag |
| ti_o | output | 1 | Transmit-done flag |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |
| ren_i | input | 1 | Receive enable |
| sm2_i | input | 1 | Qualification: require a high stop bit |
| ri_clr_i | input | 1 | Clears the receive-done flag |
| ri_o | output | 1 | Receive-done flag |
| rb8_o | output | 1 | Stop bit of the last accepted frame |
| rx_data_o | output | 8 | Receive buffer |

## Verification
On every cycle the assertions check four things. A write is followed at once by a low start bit. The transmit-done flag rises only while the line is high. The buffer and the stop flag stay fixed while the receive-done flag is set. A dropped enable forces the receiver idle. Other behaviour depends on exact frame timing and on which frames are accepted, and only the bench's scenarios can show it. That covers the bit order, the two-of-three voting, glitch rejection, dropping by flag or by stop bit, and a write that abandons a frame midway. The bench follows each of these with its cycle-by-cycle model and with a line decoder of its own.

// File: rtl/uartq_pkg.sv
package uartq_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uartq_tick_gen.sv
module uartq_tick_gen #(
   parameter int PRE_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_i,
   output logic tick_o
);
   localparam int CW = $clog2(PRE_DIV);

   generate
      if (PRE_DIV < 2) begin : g_bad_div
         $error("PRE_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          at_top;

   assign at_top = (cnt == CW'(PRE_DIV - 1));
   assign tick_o = ovf_i & at_top;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (ovf_i)
         cnt <= at_top ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/uartq_tx.sv
module uartq_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ti_clr_i,
   output logic              ti_o,
   output logic              txd_o
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int BCW        = $clog2(FRAME_BITS);
   localparam int SCW        = $clog2(OVS);

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("OVS must be at least 4");
      end
   endgenerate

   logic [FRAME_BITS-1:0] shreg;
   logic [BCW-1:0]        bitcnt;
   logic [SCW-1:0]        sub;
   logic                  busy;
   logic                  bit_end;
   logic                  done;

   assign bit_end = busy & tick_i & (sub == SCW'(OVS - 1));
   assign done    = ~wr_i & bit_end & (bitcnt == BCW'(FRAME_BITS - 1));
   assign txd_o   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '1;
         bitcnt <= '0;
         sub    <= '0;
         busy   <= 1'b0;
      end else if (wr_i) begin
         shreg  <= {1'b1, data_i, 1'b0};
         bitcnt <= '0;
         sub    <= '0;
         busy   <= 1'b1;
      end else if (busy && tick_i) begin
         if (bit_end) begin
            sub <= '0;
            if (bitcnt == BCW'(FRAME_BITS - 1)) begin
               busy <= 1'b0;
            end else begin
               bitcnt <= bitcnt + 1'b1;
               shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
            end
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ti_o <= 1'b0;
      else if (done)
         ti_o <= 1'b1;
      else if (ti_clr_i)
         ti_o <= 1'b0;
   end

   // R2
   start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !txd_o);

   // R3
   ti_on_stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ti_o) |-> (txd_o && !busy));
endmodule

// File: rtl/uartq_rx.sv
module uartq_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              ren_i,
   input  logic              sm2_i,
   input  logic              ri_clr_i,
   output logic              ri_o,
   output logic              rb8_o,
   output logic [DATA_W-1:0] data_o
);
   import uartq_pkg::*;

   localparam int SCW = $clog2(OVS);
   localparam int ICW = $clog2(DATA_W);
   localparam int MID = OVS / 2;

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("OVS must be at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync;
   logic                   rx_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk) begin
            if (!rst_n) sync <= '1;
            else        sync <= rxd_i;
         end
      end else begin : g_syncn
         always_ff @(posedge clk) begin
            if (!rst_n) sync <= '1;
            else        sync <= {sync[SYNC_STAGES-2:0], rxd_i};
         end
      end
   endgenerate

   assign rx_s = sync[SYNC_STAGES-1];

   rx_state_e         state;
   logic              last;
   logic [SCW-1:0]    sub;
   logic [ICW-1:0]    bidx;
   logic              v_a, v_b;
   logic [DATA_W-1:0] shb;
   logic              maj;
   logic              accept;

   assign maj    = maj3(v_a, v_b, rx_s);
   assign accept = ren_i & tick_i & (state == RX_STOP) & (sub == SCW'(MID))
                   & ~ri_o & (~sm2_i | maj);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         last  <= 1'b1;
         sub   <= '0;
         bidx  <= '0;
         v_a   <= 1'b0;
         v_b   <= 1'b0;
         shb   <= '0;
      end else begin
         if (tick_i && state == RX_IDLE) last <= rx_s;
         if (!ren_i) begin
            state <= RX_IDLE;
         end else if (tick_i) begin
            if (state == RX_IDLE) begin
               if (last && !rx_s) begin
                  state <= RX_START;
                  sub   <= '0;
               end
            end else begin
               sub <= (sub == SCW'(OVS - 1)) ? '0 : sub + 1'b1;
               if (sub == SCW'(MID - 2)) v_a <= rx_s;
               if (sub == SCW'(MID - 1)) v_b <= rx_s;
               if (sub == SCW'(MID)) begin
                  case (state)
                     RX_START: if (maj) begin
                        state <= RX_IDLE;
                        last  <= rx_s;
                     end
                     RX_DATA:  shb <= {maj, shb[DATA_W-1:1]};
                     RX_STOP: begin
                        state <= RX_IDLE;
                        last  <= rx_s;
                     end
                     default: ;
                  endcase
               end
               if (sub == SCW'(OVS - 1)) begin
                  if (state == RX_START) begin
                     state <= RX_DATA;
                     bidx  <= '0;
                  end else if (state == RX_DATA) begin
                     if (bidx == ICW'(DATA_W - 1)) state <= RX_STOP;
                     else                          bidx  <= bidx + 1'b1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ri_o   <= 1'b0;
         rb8_o  <= 1'b0;
         data_o <= '0;
      end else if (accept) begin
         ri_o   <= 1'b1;
         rb8_o  <= maj;
         data_o <= shb;
      end else if (ri_clr_i) begin
         ri_o   <= 1'b0;
      end
   end

   // R8
   hold_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ri_o && !ri_clr_i) |=> ($stable(data_o) && $stable(rb8_o)));

   // R7
   stop_flag_with_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rb8_o) |-> $rose(ri_o));

   // R5
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ren_i |=> (state == RX_IDLE));
endmodule

// File: rtl/uartq_top.sv
module uartq_top #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int PRE_DIV     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_ovf_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              ti_clr_i,
   output logic              ti_o,
   output logic              txd_o,
   input  logic              rxd_i,
   input  logic              ren_i,
   input  logic              sm2_i,
   input  logic              ri_clr_i,
   output logic              ri_o,
   output logic              rb8_o,
   output logic [DATA_W-1:0] rx_data_o
);
   logic sample_tick;

   uartq_tick_gen #(.PRE_DIV(PRE_DIV)) i_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovf_i  (baud_ovf_i),
      .tick_o (sample_tick)
   );

   uartq_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (sample_tick),
      .wr_i     (tx_wr_i),
      .data_i   (tx_data_i),
      .ti_clr_i (ti_clr_i),
      .ti_o     (ti_o),
      .txd_o    (txd_o)
   );

   uartq_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (sample_tick),
      .rxd_i    (rxd_i),
      .ren_i    (ren_i),
      .sm2_i    (sm2_i),
      .ri_clr_i (ri_clr_i),
      .ri_o     (ri_o),
      .rb8_o    (rb8_o),
      .data_o   (rx_data_o)
   );
endmodule

// File: tb/test_uartq_top.sv
module test_uartq_top;
   localparam int CLK_PERIOD = 10;
   localparam int PRE        = 32;
   localparam int OVS        = 16;
   localparam int BIT_CYC    = PRE * OVS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_ovf = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       ti_clr = 1'b0;
   logic       ti, txd;
   logic       rxd = 1'b1;
   logic       ren = 1'b0;
   logic       sm2 = 1'b0;
   logic       ri_clr = 1'b0;
   logic       ri, rb8;
   logic [7:0] rx_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uartq_top i_uartq_top (
      .clk(clk), .rst_n(rst_n), .baud_ovf_i(baud_ovf),
      .tx_wr_i(tx_wr), .tx_data_i(tx_data), .ti_clr_i(ti_clr),
      .ti_o(ti), .txd_o(txd), .rxd_i(rxd), .ren_i(ren), .sm2_i(sm2),
      .ri_clr_i(ri_clr), .ri_o(ri), .rb8_o(rb8), .rx_data_o(rx_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced on each rising edge
   int   m_pc;
   bit   q_tx[$];
   bit   m_busy, m_ti;
   int   m_tsub;
   bit   sy0, sy1;
   int   m_st, m_rsub, m_bidx;
   bit   m_last, m_va, m_vb, m_ri, m_rb8;
   logic [7:0] m_shb, m_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; q_tx.delete(); m_busy = 0; m_ti = 0; m_tsub = 0;
         sy0 = 1; sy1 = 1; m_st = 0; m_rsub = 0; m_bidx = 0;
         m_last = 1; m_va = 0; m_vb = 0; m_ri = 0; m_rb8 = 0;
         m_shb = 0; m_data = 0;
      end else begin
         bit tk, rs, done, acc, maj, ri_old, last_o;
         int st_o, sub_o;
         tk = baud_ovf && (m_pc == PRE - 1);
         if (baud_ovf) m_pc = (m_pc == PRE - 1) ? 0 : m_pc + 1;
         rs = sy1; sy1 = sy0; sy0 = rxd;
         // transmitter
         done = 0;
         if (tx_wr) begin
            q_tx.delete();
            q_tx.push_back(1'b0);
            for (int i = 0; i < 8; i++) q_tx.push_back(tx_data[i]);
            q_tx.push_back(1'b1);
            m_busy = 1; m_tsub = 0;
         end else if (m_busy && tk) begin
            if (m_tsub == OVS - 1) begin
               m_tsub = 0;
               void'(q_tx.pop_front());
               if (q_tx.size() == 0) begin m_busy = 0; done = 1; end
            end else m_tsub++;
         end
         if (done) m_ti = 1; else if (ti_clr) m_ti = 0;
         // receiver
         acc = 0; ri_old = m_ri; st_o = m_st; sub_o = m_rsub; last_o = m_last;
         maj = (m_va && m_vb) || (m_va && rs) || (m_vb && rs);
         if (tk && st_o == 0) m_last = rs;
         if (!ren) m_st = 0;
         else if (tk) begin
            if (st_o == 0) begin
               if (last_o && !rs) begin m_st = 1; m_rsub = 0; end
            end else begin
               m_rsub = (sub_o == OVS - 1) ? 0 : sub_o + 1;
               if (sub_o == OVS/2 - 2) m_va = rs;
               if (sub_o == OVS/2 - 1) m_vb = rs;
               if (sub_o == OVS/2) begin
                  if (st_o == 1 && maj) begin m_st = 0; m_last = rs; end
                  if (st_o == 2) m_shb = {maj, m_shb[7:1]};
                  if (st_o == 3) begin
                     m_st = 0; m_last = rs;
                     if (!ri_old && (!sm2 || maj)) acc = 1;
                  end
               end
               if (sub_o == OVS - 1) begin
                  if (st_o == 1) begin m_st = 2; m_bidx = 0; end
                  else if (st_o == 2) begin
                     if (m_bidx == 7) m_st = 3; else m_bidx++;
                  end
               end
            end
         end
         if (acc) begin m_data = m_shb; m_rb8 = maj; m_ri = 1; end
         else if (ri_clr) m_ri = 0;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 txd", txd, (m_busy && q_tx.size() > 0) ? q_tx[0] : 1'b1);
         chk("R3 ti", ti, m_ti);
         chk("R7 ri", ri, m_ri);
         chk("R8 rx_data", rx_data, m_data);
         chk("R9 rb8", rb8, m_rb8);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rx_frame(input logic [7:0] b, input bit stopb);
      rxd = 1'b0; cyc(BIT_CYC);
      for (int i = 0; i < 8; i++) begin rxd = b[i]; cyc(BIT_CYC); end
      rxd = stopb; cyc(BIT_CYC);
      rxd = 1'b1; cyc(BIT_CYC);
   endtask

   task automatic decode_tx(output logic [7:0] b, output logic stp);
      while (txd !== 1'b0) @(negedge clk);
      cyc(BIT_CYC + BIT_CYC/2);
      for (int i = 0; i < 8; i++) begin b[i] = txd; cyc(BIT_CYC); end
      stp = txd;
   endtask

   task automatic write_tx(input logic [7:0] b);
      tx_data = b; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
   endtask

   task automatic pulse_ri_clr();
      ri_clr = 1'b1; cyc(1); ri_clr = 1'b0;
   endtask

   task automatic pulse_ti_clr();
      ti_clr = 1'b1; cyc(1); ti_clr = 1'b0;
   endtask

   task automatic wait_ti();
      for (int i = 0; i < 12 * BIT_CYC; i++) begin
         if (ti === 1'b1) break;
         cyc(1);
      end
   endtask

   initial begin
      cyc(200000 - 10);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] db;
      logic       ds;
      cyc(4);
      // R11 reset state
      chk("R11 txd", txd, 1'b1);
      chk("R11 ti", ti, 1'b0);
      chk("R11 ri", ri, 1'b0);
      chk("R11 rb8", rb8, 1'b0);
      chk("R11 rx_data", rx_data, 8'h00);
      rst_n = 1'b1;
      cyc(3);
      baud_ovf = 1'b1;
      cyc(5);

      // R2, R1, R3: single transmit
      fork
         begin
            write_tx(8'hA5);
            chk("R2 start low", txd, 1'b0);
         end
         decode_tx(db, ds);
      join
      chk("R1 tx byte", db, 8'hA5);
      chk("R1 tx stop", ds, 1'b1);
      wait_ti();
      chk("R3 ti set", ti, 1'b1);
      cyc(20);
      chk("R3 ti held", ti, 1'b1);
      pulse_ti_clr();
      chk("R3 ti cleared", ti, 1'b0);

      // R7: accepted frame
      ren = 1'b1; cyc(40);
      rx_frame(8'h3C, 1'b1);
      chk("R7 ri", ri, 1'b1);
      chk("R7 data", rx_data, 8'h3C);
      chk("R7 rb8", rb8, 1'b1);

      // R8: dropped while ri set
      rx_frame(8'h55, 1'b1);
      chk("R8 data kept", rx_data, 8'h3C);
      chk("R8 ri still", ri, 1'b1);

      // R10: clear ri
      pulse_ri_clr();
      chk("R10 ri clear", ri, 1'b0);

      // R9: qualification drops low stop bit
      sm2 = 1'b1;
      rx_frame(8'h99, 1'b0);
      chk("R9 dropped ri", ri, 1'b0);
      chk("R9 dropped data", rx_data, 8'h3C);
      chk("R9 dropped rb8", rb8, 1'b1);
      sm2 = 1'b0;
      rx_frame(8'h66, 1'b0);
      chk("R9 accepted ri", ri, 1'b1);
      chk("R9 accepted data", rx_data, 8'h66);
      chk("R9 accepted rb8", rb8, 1'b0);
      pulse_ri_clr();

      // R5: receiver disabled
      ren = 1'b0;
      rx_frame(8'h11, 1'b1);
      chk("R5 ignored ri", ri, 1'b0);
      chk("R5 ignored data", rx_data, 8'h66);
      ren = 1'b1; cyc(40);

      // R6: glitch rejection, then a valid frame
      rxd = 1'b0; cyc(40); rxd = 1'b1; cyc(2 * BIT_CYC);
      chk("R6 glitch ri", ri, 1'b0);
      rx_frame(8'hC3, 1'b1);
      chk("R6 after glitch data", rx_data, 8'hC3);
      chk("R6 after glitch ri", ri, 1'b1);
      pulse_ri_clr();

      // R4: overwrite during a frame
      write_tx(8'h81);
      cyc(2000);
      write_tx(8'h7E);
      cyc(8 * BIT_CYC);
      chk("R4 no ti for abandoned", ti, 1'b0);
      wait_ti();
      chk("R4 ti after new byte", ti, 1'b1);
      pulse_ti_clr();
      cyc(BIT_CYC);

      // R1, R7: full duplex
      fork
         begin write_tx(8'h5A); end
         decode_tx(db, ds);
         rx_frame(8'hE7, 1'b1);
      join
      chk("R1 duplex tx byte", db, 8'h5A);
      chk("R7 duplex rx data", rx_data, 8'hE7);
      wait_ti();
      chk("R3 duplex ti", ti, 1'b1);

      cyc(10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule